// File: doc/BRIEF.md
# Per-Frame Trigger Timestamp Recorder

This block watches an asynchronous trigger line while a pixel sensor is read out line by line. It runs its own readout-line timer, which steps through a fixed number of lines per frame and wraps at the end of each frame. Every rising edge on the trigger line, once synchronised, increments a running trigger total. The block also stores a 32-bit stamp that pairs the low half of that total with the readout line being scanned at that moment.

Stamps are collected per frame, up to a fixed cap. Triggers beyond the cap are still counted but not stored, and they raise an overflow flag. On the first cycle of each new frame the block pulses a done strobe. With it come the finished frame's stored-trigger count, its overflow flag, and a flag saying that one more frame is needed because a trigger landed on a late readout line. Storage uses two banks that swap at each frame boundary. The stamps of the finished frame can therefore be read by address during the whole of the following frame, while new stamps go to the other bank.

Top module: `trig_stamp_rec`

## Requirements
- R1: While reset is high, and after it, the outputs `trig_total`, `frame_cnt`, `frame_ovf`, `frame_late`, `frame_done` and `line_idx` are all zero.
- R2: Each rising edge of `trig_in` adds exactly one to `trig_total`, however long the pulse is held. The edge passes two synchroniser flops, so the total changes on the third rising clock edge after the input rises.
- R3: `line_idx` advances by one every LINE_CYCLES clocks, counts from 0 to LINES-1 and then wraps to 0. One frame is LINES*LINE_CYCLES clocks, and the first frame starts on the first clock after reset is released.
- R4: A stored stamp holds the post-increment value of the trigger total, bits 15:0, in bits 31:16. It holds the readout line index, zero-extended, in bits 15:0.
- R5: At most MAX_STAMPS stamps are stored per frame. Further triggers in that frame still advance `trig_total`, are not stored, and make `frame_ovf` read 1 for that frame.
- R6: `frame_done` is a one-cycle pulse in the first clock of each frame after the first. Together with it, `frame_cnt` gives the number of stamps stored in the frame that just ended.
- R7: `frame_late` reads 1 for a finished frame if any trigger in it landed on a line index of LATE_LINE or above. This includes triggers dropped by the cap.
- R8: A trigger belongs to the frame in which its synchronised edge is detected, with no latency compensation. An edge in the last clock of a frame counts in that frame. An edge in the first clock of the next frame counts in the next frame.
- R9: The stamps of a finished frame sit at `rd_addr` 0 to `frame_cnt`-1, in arrival order, and `rd_data` returns them until the next `frame_done`. Each frame's storage starts again at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous trigger line |
| rd_addr | input | ADDR_W | Stamp address within the finished frame |
| line_idx | output | LINE_W | Readout line currently being scanned |
| trig_total | output | CNT_W | Running count of accepted trigger edges |
| frame_done | output | 1 | One-cycle strobe at each frame boundary |
| frame_cnt | output | PTR_W | Stamps stored in the finished frame |
| frame_ovf | output | 1 | Finished frame had more triggers than the cap |
| frame_late | output | 1 | Finished frame had a trigger on a late line |
| rd_data | output | 32 | Stamp at `rd_addr` in the finished frame |

## Verification
The frame pattern is tried with no triggers, a single trigger, a few widely spaced ones, and exactly the cap. The cap-filling case separates a full frame from an overflowing one, and the overflowing frame's dropped trigger sits on a late line, which shows whether lateness is taken from every trigger or only from stored ones. Single triggers one line either side of the late threshold pin down the comparison. An edge on the last clock of a frame, and another on the first clock of the next, show which frame receives a trigger at the boundary. A reset in mid-frame while the trigger is high shows that counters and line timer restart cleanly.

// File: rtl/trig_stamp_pkg.sv
package trig_stamp_pkg;

    localparam int STAMP_W = 32;
    localparam int HALF_W  = 16;

    typedef struct packed {
        logic [HALF_W-1:0] seq;   // low half of trigger total after increment
        logic [HALF_W-1:0] line;  // readout line index, zero-extended
    } stamp_t;

    typedef struct packed {
        logic ovf;
        logic late;
    } frame_flags_t;

    function automatic stamp_t make_stamp(input logic [HALF_W-1:0] seq_v,
                                          input logic [HALF_W-1:0] line_v);
        stamp_t s;
        s.seq  = seq_v;
        s.line = line_v;
        return s;
    endfunction

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic trig_async,
    output logic edge_pulse
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= trig_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign edge_pulse = sync_q & ~prev_q;

    // R2: a held level yields one edge only
    p_edge_single_r2: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |=> !edge_pulse);

endmodule

// File: rtl/line_timer.sv
module line_timer #(
    parameter int LINE_CYCLES = 16,
    parameter int LINES       = 576,
    parameter int LINE_W      = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [LINE_W-1:0] line_idx,
    output logic              frame_last
);
    localparam int SUB_W = (LINE_CYCLES > 1) ? $clog2(LINE_CYCLES) : 1;

    logic [SUB_W-1:0]  sub_q;
    logic [LINE_W-1:0] line_q;
    logic              tick;
    logic              at_last_line;

    assign tick         = (sub_q == SUB_W'(LINE_CYCLES - 1));
    assign at_last_line = (line_q == LINE_W'(LINES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q  <= '0;
            line_q <= '0;
        end else if (tick) begin
            sub_q  <= '0;
            line_q <= at_last_line ? '0 : line_q + LINE_W'(1);
        end else begin
            sub_q  <= sub_q + SUB_W'(1);
        end
    end

    assign line_idx   = line_q;
    assign frame_last = tick & at_last_line;

    // R3: after the last line of a frame the index restarts at 0
    p_line_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        frame_last |=> (line_idx == '0));

    // R3: the index never passes the last line
    p_line_range_r3: assert property (@(posedge clk) disable iff (rst)
        line_idx <= LINE_W'(LINES - 1));

endmodule

// File: rtl/stamp_store.sv
module stamp_store
    import trig_stamp_pkg::*;
#(
    parameter int MAX_STAMPS = 288,
    parameter int LINE_W     = 10,
    parameter int LATE_LINE  = 572,
    parameter int PTR_W      = $clog2(MAX_STAMPS + 1),
    parameter int ADDR_W     = $clog2(MAX_STAMPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [HALF_W-1:0] seq_next,
    input  logic              frame_last,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              frame_done,
    output logic [PTR_W-1:0]  frame_cnt,
    output frame_flags_t      frame_flags,
    output logic [STAMP_W-1:0] rd_data
);
    stamp_t mem [2][MAX_STAMPS];

    logic [PTR_W-1:0] ptr_q, ptr_nx;
    frame_flags_t     acc_q, acc_nx;
    logic             bank_q;
    logic             room, do_store;

    assign room     = (ptr_q < PTR_W'(MAX_STAMPS));
    assign do_store = hit & room;

    always_comb begin
        ptr_nx      = ptr_q + (do_store ? PTR_W'(1) : PTR_W'(0));
        acc_nx.ovf  = acc_q.ovf  | (hit & ~room);
        acc_nx.late = acc_q.late | (hit & (line_idx >= LINE_W'(LATE_LINE)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q       <= '0;
            acc_q       <= '0;
            bank_q      <= 1'b0;
            frame_done  <= 1'b0;
            frame_cnt   <= '0;
            frame_flags <= '0;
        end else if (frame_last) begin
            frame_cnt   <= ptr_nx;
            frame_flags <= acc_nx;
            frame_done  <= 1'b1;
            ptr_q       <= '0;
            acc_q       <= '0;
            bank_q      <= ~bank_q;
        end else begin
            frame_done  <= 1'b0;
            ptr_q       <= ptr_nx;
            acc_q       <= acc_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (do_store)
            mem[bank_q][ptr_q[ADDR_W-1:0]] <= make_stamp(seq_next, HALF_W'(line_idx));
    end

    always_comb begin
        if (int'(rd_addr) < MAX_STAMPS)
            rd_data = mem[~bank_q][rd_addr];
        else
            rd_data = '0;
    end

    // R5: the write pointer never passes the cap
    p_ptr_cap_r5: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= PTR_W'(MAX_STAMPS));

    // R5: overflow only once the frame storage is full
    p_ovf_full_r5: assert property (@(posedge clk) disable iff (rst)
        acc_q.ovf |-> (ptr_q == PTR_W'(MAX_STAMPS)));

    // R6: the done strobe lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R9: each frame starts filling at address 0
    p_ptr_clear_r9: assert property (@(posedge clk) disable iff (rst)
        frame_last |=> (ptr_q == '0));

endmodule

// File: rtl/trig_stamp_rec.sv
module trig_stamp_rec
    import trig_stamp_pkg::*;
#(
    parameter int LINE_CYCLES = 16,
    parameter int LINES       = 576,
    parameter int MAX_STAMPS  = 288,
    parameter int LATE_LINE   = 572,
    parameter int CNT_W       = 32,
    parameter int LINE_W      = $clog2(LINES),
    parameter int PTR_W       = $clog2(MAX_STAMPS + 1),
    parameter int ADDR_W      = $clog2(MAX_STAMPS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_in,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [LINE_W-1:0]  line_idx,
    output logic [CNT_W-1:0]   trig_total,
    output logic               frame_done,
    output logic [PTR_W-1:0]   frame_cnt,
    output logic               frame_ovf,
    output logic               frame_late,
    output logic [STAMP_W-1:0] rd_data
);
    logic              hit;
    logic              frame_last;
    logic [HALF_W-1:0] seq_next;
    frame_flags_t      flags;

    trig_edge_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .trig_async (trig_in),
        .edge_pulse (hit)
    );

    line_timer #(
        .LINE_CYCLES (LINE_CYCLES),
        .LINES       (LINES),
        .LINE_W      (LINE_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .line_idx   (line_idx),
        .frame_last (frame_last)
    );

    always_ff @(posedge clk) begin
        if (rst)
            trig_total <= '0;
        else if (hit)
            trig_total <= trig_total + CNT_W'(1);
    end

    assign seq_next = trig_total[HALF_W-1:0] + HALF_W'(1);

    stamp_store #(
        .MAX_STAMPS (MAX_STAMPS),
        .LINE_W     (LINE_W),
        .LATE_LINE  (LATE_LINE),
        .PTR_W      (PTR_W),
        .ADDR_W     (ADDR_W)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .hit         (hit),
        .line_idx    (line_idx),
        .seq_next    (seq_next),
        .frame_last  (frame_last),
        .rd_addr     (rd_addr),
        .frame_done  (frame_done),
        .frame_cnt   (frame_cnt),
        .frame_flags (flags),
        .rd_data     (rd_data)
    );

    assign frame_ovf  = flags.ovf;
    assign frame_late = flags.late;

    // R2: the total holds or steps by exactly one per clock
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (trig_total == $past(trig_total)) || (trig_total == $past(trig_total) + CNT_W'(1)));

    // R6: the stored count never exceeds the cap
    p_cnt_cap_r6: assert property (@(posedge clk) disable iff (rst)
        frame_cnt <= PTR_W'(MAX_STAMPS));

endmodule

// File: tb/trig_stamp_rec_tb_top.sv
`timescale 1ns/1ps
module trig_stamp_rec_tb_top;
    localparam int LC    = 2;
    localparam int NL    = 16;
    localparam int CAP   = 4;
    localparam int LATE  = 12;
    localparam int FRAME = LC * NL;
    localparam int LW    = $clog2(NL);
    localparam int PW    = $clog2(CAP + 1);
    localparam int AW    = $clog2(CAP);

    // {trigger count, first edge position, spacing} per frame
    localparam int N_VEC = 8;
    localparam int VTAB [N_VEC][3] = '{
        '{1,  2, 4},
        '{3,  4, 6},
        '{4,  2, 6},
        '{6,  2, 5},
        '{1, 23, 4},
        '{1, 24, 4},
        '{2, 27, 4},
        '{0,  2, 4}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_in = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [LW-1:0] line_idx;
    logic [31:0]   trig_total;
    logic          frame_done;
    logic [PW-1:0] frame_cnt;
    logic          frame_ovf, frame_late;
    logic [31:0]   rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int total = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    trig_stamp_rec #(
        .LINE_CYCLES (LC),
        .LINES       (NL),
        .MAX_STAMPS  (CAP),
        .LATE_LINE   (LATE)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .trig_in    (trig_in),
        .rd_addr    (rd_addr),
        .line_idx   (line_idx),
        .trig_total (trig_total),
        .frame_done (frame_done),
        .frame_cnt  (frame_cnt),
        .frame_ovf  (frame_ovf),
        .frame_late (frame_late),
        .rd_data    (rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit trig_level(input int c, input int n, input int st, input int sp);
        for (int i = 0; i < n; i++) begin
            int p = st + i * sp;
            if (c == p - 2 || c == p - 1) return 1'b1;
        end
        return 1'b0;
    endfunction

    // drive one frame; starts and ends at a falling edge in the frame's first clock
    task automatic run_frame(input int n, input int st, input int sp, input bit chk_line);
        for (int c = 0; c < FRAME; c++) begin
            trig_in = trig_level(c, n, st, sp);
            if (chk_line) chk("R3 line index", 32'(line_idx), 32'(c / LC));
            @(negedge clk);
        end
        trig_in = 1'b0;
    endtask

    task automatic check_frame(input int n, input int st, input int sp);
        int  stored = (n < CAP) ? n : CAP;
        bit  late = 1'b0;
        for (int i = 0; i < n; i++)
            if ((st + i * sp) / LC >= LATE) late = 1'b1;
        total += n;
        chk("R6 done strobe", 32'(frame_done), 32'd1);
        chk("R6 stored count", 32'(frame_cnt), 32'(stored));
        chk("R5 overflow flag", 32'(frame_ovf), 32'(n > CAP));
        chk("R7 late flag", 32'(frame_late), 32'(late));
        chk("R2 trigger total", trig_total, 32'(total));
        for (int k = 0; k < stored; k++) begin
            int p = st + k * sp;
            rd_addr = AW'(k);
            #0.5;
            chk("R4 R9 stamp", rd_data, {16'(total - n + k + 1), 16'(p / LC)});
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 total", trig_total, 32'd0);
        chk("R1 count", 32'(frame_cnt), 32'd0);
        chk("R1 flags", {30'd0, frame_ovf, frame_late}, 32'd0);
        chk("R1 done", 32'(frame_done), 32'd0);
        chk("R1 line", 32'(line_idx), 32'd0);
        rst = 1'b0;

        for (int v = 0; v < N_VEC; v++) begin
            run_frame(VTAB[v][0], VTAB[v][1], VTAB[v][2], v == 0);
            check_frame(VTAB[v][0], VTAB[v][1], VTAB[v][2]);
            @(negedge clk);
            chk("R6 strobe width", 32'(frame_done), 32'd0);
            repeat (FRAME - 1) @(negedge clk);
        end

        // R8: pulse raised so its edge lands in the first clock of the next frame
        for (int c = 0; c < FRAME; c++) begin
            trig_in = (c >= FRAME - 2);
            @(negedge clk);
        end
        trig_in = 1'b0;
        chk("R8 boundary frame A count", 32'(frame_cnt), 32'd0);
        chk("R8 boundary frame A total", trig_total, 32'(total));
        run_frame(0, 2, 4, 1'b0);
        total += 1;
        chk("R8 boundary frame B count", 32'(frame_cnt), 32'd1);
        chk("R2 boundary total", trig_total, 32'(total));
        rd_addr = '0;
        #0.5;
        chk("R8 boundary stamp line 0", rd_data, {16'(total), 16'd0});

        // R1: reset in mid-frame with the trigger held high
        @(negedge clk);
        trig_in = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid reset total", trig_total, 32'd0);
        chk("R1 mid reset line", 32'(line_idx), 32'd0);
        chk("R1 mid reset count", 32'(frame_cnt), 32'd0);
        chk("R1 mid reset flags", {30'd0, frame_ovf, frame_late}, 32'd0);
        trig_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule